// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block is the tag side of a set-associative cache. Each way of each set stores a line address together with one of four access-permission states, in place of a plain valid bit. A cache controller sends it one command per cycle. The commands are: full access check, relaxed access check, presence test, availability test, allocate, deallocate, permission change, victim probe and touch. The directory answers with a hit flag, a way index, the way's permission, a victim address and an error flag.

The set is chosen by the low bits of the line address. Every set keeps true-LRU ordering as per-way age counters, and a victim probe returns the oldest way of a full set. A newly allocated line is tagged but not yet usable (permission Invalid) until the controller raises its permission. Commands that would corrupt the directory are refused with an error and leave the state untouched: allocating into a full set, allocating an address that is already present, and freeing, changing or touching an address that is not present.

Top module: `tag_directory`

## Requirements
- R1: After reset every way of every set holds address 0 with permission NotPresent (encoding 0), `rsp_valid` is low, and a presence test of any address misses.
- R2: Every command accepted with `req_valid` high produces `rsp_valid` high exactly one clock later. The response reflects the directory state before that command's own update.
- R3: The set index is `req_addr[SET_BITS-1:0]`. A way matches only if its stored address equals `req_addr` and its permission is not NotPresent. The presence test (op 3) reports that match in `rsp_hit`. `rsp_way` and `rsp_perm` then give the matched way and its permission, or 0 and NotPresent on a miss.
- R4: A full access check (op 1) hits for any request kind when the matched permission is ReadWrite (3). It hits for load (kind 0) or fetch (kind 1) when the matched permission is ReadOnly (2). Every other case misses, including store (kind 2) to ReadOnly and any kind to Invalid (1).
- R5: A relaxed access check (op 2) hits whenever a way matches, whatever its permission, including Invalid.
- R6: A full or relaxed access check that finds a match makes the matched way most recently used, even when the full check refuses the access.
- R7: An availability test (op 4) reports `rsp_hit` high when some way of the set stores `req_addr` with any permission, or some way of the set is NotPresent.
- R8: An allocate (op 5) writes `req_addr` into the lowest-numbered NotPresent way of the set and sets that way to Invalid. It makes that way most recently used and responds with `rsp_hit` high, that way in `rsp_way`, and Invalid in `rsp_perm`.
- R9: An allocate into a set with no NotPresent way, or of an address that already matches, raises `rsp_error` with `rsp_hit` low and changes no state.
- R10: A deallocate (op 6) sets the matched way to NotPresent. A permission change (op 7) writes `req_perm` into the matched way. Both report the previous permission, and both raise `rsp_error` without any change when no way matches.
- R11: Replacement is true LRU. A touch gives the touched way age 0 and ages by one every way that was younger than it. After reset way w has age w. A victim probe (op 8) on a set with no available way returns the oldest way in `rsp_way` and its stored address in `rsp_victim`.
- R12: A victim probe on a set that passes the availability test, or a touch (op 9) of an address that does not match, raises `rsp_error` and changes no state. A matching touch responds with `rsp_hit` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is present this cycle |
| req_op | input | 4 | Command code: 1 access, 2 relaxed, 3 present, 4 avail, 5 alloc, 6 free, 7 set-perm, 8 probe, 9 touch |
| req_kind | input | 2 | Access kind: 0 load, 1 fetch, 2 store |
| req_addr | input | ADDR_W | Line address; low SET_BITS bits select the set |
| req_perm | input | 2 | New permission for a permission change |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Command-specific hit / success flag |
| rsp_way | output | WAY_W | Matched, allocated or victim way |
| rsp_perm | output | 2 | Permission of the reported way |
| rsp_victim | output | ADDR_W | Stored address of the victim way for a probe, else 0 |
| rsp_error | output | 1 | Command refused, state unchanged |

## Verification
Every result of this block is due on the first rising edge after the command is presented. The bench drives a command at a falling edge and reads the matching response at the next falling edge. The driver predicts each response from a bench-side model of tags, permissions and ages, and queues the prediction as it issues the command. The monitor pops one queued prediction per `rsp_valid` cycle, so a response that arrives a cycle late or early is paired with the wrong prediction and shows up as a mismatch. Directed sequences cover filling and overflowing a set, every permission/kind pairing, LRU reordering and probing, and a long mixed run follows them.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    PERM_ABSENT = 2'd0,
    PERM_INVAL  = 2'd1,
    PERM_RDONLY = 2'd2,
    PERM_RDWR   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_STORE = 2'd2
  } kind_e;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_ACCESS  = 4'd1,
    OP_RELAXED = 4'd2,
    OP_PRESENT = 4'd3,
    OP_AVAIL   = 4'd4,
    OP_ALLOC   = 4'd5,
    OP_FREE    = 4'd6,
    OP_SETPERM = 4'd7,
    OP_PROBE   = 4'd8,
    OP_TOUCH   = 4'd9
  } op_e;

endpackage

// File: rtl/tagdir_store.sv
module tagdir_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int SET_W  = 2,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic [ADDR_W-1:0] rd_tag  [WAYS],
  output logic [1:0]        rd_perm [WAYS],
  input  logic              wr_tag_en,
  input  logic              wr_perm_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [1:0]        wr_perm
);

  logic [ADDR_W-1:0] tag_q  [SETS][WAYS];
  logic [ADDR_W-1:0] tag_d  [SETS][WAYS];
  logic [1:0]        perm_q [SETS][WAYS];
  logic [1:0]        perm_d [SETS][WAYS];
  logic              upd_en;

  assign upd_en = wr_tag_en | wr_perm_en;

  always_comb begin
    tag_d  = tag_q;
    perm_d = perm_q;
    if (wr_tag_en)  tag_d[wr_set][wr_way]  = wr_tag;
    if (wr_perm_en) perm_d[wr_set][wr_way] = wr_perm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          perm_q[s][w] <= 2'd0;
        end
      end
    end else if (upd_en) begin
      tag_q  <= tag_d;
      perm_q <= perm_d;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tag[w]  = tag_q[rd_set][w];
      rd_perm[w] = perm_q[rd_set][w];
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set_chk
    for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
      // R10
      perm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_perm_en && wr_set == SET_W'(s) && wr_way == WAY_W'(w))
        |=> (perm_q[s][w] == $past(wr_perm)));
    end
  end

endmodule

// File: rtl/tagdir_lookup.sv
module tagdir_lookup #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int WAY_W  = 2
) (
  input  logic [ADDR_W-1:0] rd_tag  [WAYS],
  input  logic [1:0]        rd_perm [WAYS],
  input  logic [ADDR_W-1:0] req_addr,
  output logic              match,
  output logic [WAY_W-1:0]  match_way,
  output logic [1:0]        match_perm,
  output logic              tag_seen,
  output logic              free_found,
  output logic [WAY_W-1:0]  free_way
);

  always_comb begin
    match      = 1'b0;
    match_way  = '0;
    match_perm = 2'd0;
    tag_seen   = 1'b0;
    free_found = 1'b0;
    free_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_tag[w] == req_addr) begin
        tag_seen = 1'b1;
        if (rd_perm[w] != 2'd0 && !match) begin
          match      = 1'b1;
          match_way  = WAY_W'(w);
          match_perm = rd_perm[w];
        end
      end
      if (rd_perm[w] == 2'd0 && !free_found) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim_way
);

  localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] age_d [SETS][WAYS];
  logic [WAY_W-1:0] cur_age;
  logic [WAYS-1:0]  oldest [SETS];

  always_comb begin
    age_d   = age_q;
    cur_age = age_q[touch_set][touch_way];
    if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[touch_set][w] < cur_age)
          age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
      end
      age_d[touch_set][touch_way] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[rd_set][w] == AGE_MAX) victim_way = WAY_W'(w);
    end
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        oldest[s][w] = (age_q[s][w] == AGE_MAX);
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_age_chk
    // R11
    oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest[s]));
    for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
      // R11
      touch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && touch_set == SET_W'(s) && touch_way == WAY_W'(w))
        |=> (age_q[s][w] == '0));
    end
  end

endmodule

// File: rtl/tag_directory.sv
module tag_directory
  import tagdir_pkg::*;
#(
  parameter int SET_BITS = 2,
  parameter int WAYS     = 4,
  parameter int ADDR_W   = 16,
  localparam int SETS    = 1 << SET_BITS,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_perm,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [1:0]        rsp_perm,
  output logic [ADDR_W-1:0] rsp_victim,
  output logic              rsp_error
);

  logic [SET_BITS-1:0] sel_set;
  logic [ADDR_W-1:0]   rd_tag  [WAYS];
  logic [1:0]          rd_perm [WAYS];
  logic                match, tag_seen, free_found, avail, acc_ok;
  logic [WAY_W-1:0]    match_way, free_way, victim_way;
  logic [1:0]          match_perm;

  logic                wr_tag_en, wr_perm_en, touch_en;
  logic [WAY_W-1:0]    wr_way, touch_way;
  logic [1:0]          wr_perm;

  logic                hit_d, err_d;
  logic [WAY_W-1:0]    way_d;
  logic [1:0]          perm_d;
  logic [ADDR_W-1:0]   victim_d;

  logic                valid_q, hit_q, err_q;
  logic [WAY_W-1:0]    way_q;
  logic [1:0]          perm_q;
  logic [ADDR_W-1:0]   victim_q;
  logic [3:0]          op_q;
  logic [1:0]          kind_q;

  assign sel_set = req_addr[SET_BITS-1:0];

  tagdir_store #(
    .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .SET_W(SET_BITS), .WAY_W(WAY_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(sel_set), .rd_tag(rd_tag), .rd_perm(rd_perm),
    .wr_tag_en(wr_tag_en), .wr_perm_en(wr_perm_en), .wr_set(sel_set),
    .wr_way(wr_way), .wr_tag(req_addr), .wr_perm(wr_perm)
  );

  tagdir_lookup #(
    .WAYS(WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)
  ) u_lookup (
    .rd_tag(rd_tag), .rd_perm(rd_perm), .req_addr(req_addr),
    .match(match), .match_way(match_way), .match_perm(match_perm),
    .tag_seen(tag_seen), .free_found(free_found), .free_way(free_way)
  );

  tagdir_lru #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_BITS), .WAY_W(WAY_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(sel_set),
    .touch_way(touch_way), .rd_set(sel_set), .victim_way(victim_way)
  );

  assign avail  = tag_seen | free_found;
  assign acc_ok = match & ((match_perm == PERM_RDWR) |
                           ((match_perm == PERM_RDONLY) & (req_kind != KIND_STORE)));

  always_comb begin
    wr_tag_en  = 1'b0;
    wr_perm_en = 1'b0;
    wr_way     = match_way;
    wr_perm    = PERM_ABSENT;
    touch_en   = 1'b0;
    touch_way  = match_way;
    hit_d      = 1'b0;
    err_d      = 1'b0;
    way_d      = match ? match_way : '0;
    perm_d     = match ? match_perm : PERM_ABSENT;
    victim_d   = '0;
    if (req_valid) begin
      case (op_e'(req_op))
        OP_ACCESS: begin
          hit_d    = acc_ok;
          touch_en = match;
        end
        OP_RELAXED: begin
          hit_d    = match;
          touch_en = match;
        end
        OP_PRESENT: hit_d = match;
        OP_AVAIL:   hit_d = avail;
        OP_ALLOC: begin
          if (match || !free_found) begin
            err_d = 1'b1;
          end else begin
            wr_tag_en  = 1'b1;
            wr_perm_en = 1'b1;
            wr_way     = free_way;
            wr_perm    = PERM_INVAL;
            touch_en   = 1'b1;
            touch_way  = free_way;
            hit_d      = 1'b1;
            way_d      = free_way;
            perm_d     = PERM_INVAL;
          end
        end
        OP_FREE: begin
          err_d      = !match;
          hit_d      = match;
          wr_perm_en = match;
          wr_perm    = PERM_ABSENT;
        end
        OP_SETPERM: begin
          err_d      = !match;
          hit_d      = match;
          wr_perm_en = match;
          wr_perm    = req_perm;
        end
        OP_PROBE: begin
          if (avail) begin
            err_d = 1'b1;
          end else begin
            way_d    = victim_way;
            perm_d   = rd_perm[victim_way];
            victim_d = rd_tag[victim_way];
          end
        end
        OP_TOUCH: begin
          err_d    = !match;
          hit_d    = match;
          touch_en = match;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      hit_q    <= 1'b0;
      err_q    <= 1'b0;
      way_q    <= '0;
      perm_q   <= 2'd0;
      victim_q <= '0;
      op_q     <= 4'd0;
      kind_q   <= 2'd0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        hit_q    <= hit_d;
        err_q    <= err_d;
        way_q    <= way_d;
        perm_q   <= perm_d;
        victim_q <= victim_d;
        op_q     <= req_op;
        kind_q   <= req_kind;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_hit    = hit_q;
  assign rsp_error  = err_q;
  assign rsp_way    = way_q;
  assign rsp_perm   = perm_q;
  assign rsp_victim = victim_q;

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R4
  store_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_ACCESS && kind_q == KIND_STORE && rsp_hit)
    |-> (rsp_perm == PERM_RDWR));

  // R9
  error_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> !rsp_hit);

  // R9
  refused_alloc_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_ALLOC && match) |-> !wr_tag_en);

endmodule

// File: tb/test_tag_directory.sv
module test_tag_directory;
  import tagdir_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SB = 2;
  localparam int NW = 4;
  localparam int AW = 16;
  localparam int NS = 1 << SB;
  localparam int WW = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [3:0]    req_op;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_perm;
  logic          rsp_valid, rsp_hit, rsp_error;
  logic [WW-1:0] rsp_way;
  logic [1:0]    rsp_perm;
  logic [AW-1:0] rsp_victim;

  tag_directory #(.SET_BITS(SB), .WAYS(NW), .ADDR_W(AW)) i_tag_directory (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_kind(req_kind), .req_addr(req_addr), .req_perm(req_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_perm(rsp_perm), .rsp_victim(rsp_victim), .rsp_error(rsp_error)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic          hit;
    logic [WW-1:0] way;
    logic [1:0]    perm;
    logic [AW-1:0] victim;
    logic          err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;

  logic [AW-1:0] m_tag  [NS][NW];
  logic [1:0]    m_perm [NS][NW];
  int            m_age  [NS][NW];

  function automatic void m_touch(int s, int w);
    int a = m_age[s][w];
    for (int v = 0; v < NW; v++) if (m_age[s][v] < a) m_age[s][v]++;
    m_age[s][w] = 0;
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R3";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R10";
      4'd7: return "R10";
      4'd8: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic issue(string rtag, logic [3:0] op, logic [AW-1:0] addr,
                       logic [1:0] kind, logic [1:0] perm);
    exp_t e;
    int   s, mt, fr, vw;
    bit   seen, avail;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_kind = kind; req_perm = perm;
    s = int'(addr[SB-1:0]); mt = -1; fr = -1; seen = 0; vw = 0;
    for (int w = 0; w < NW; w++) begin
      if (m_tag[s][w] == addr) begin
        seen = 1;
        if (m_perm[s][w] != 2'd0 && mt < 0) mt = w;
      end
      if (m_perm[s][w] == 2'd0 && fr < 0) fr = w;
      if (m_age[s][w] > m_age[s][vw]) vw = w;
    end
    avail = seen || (fr >= 0);
    e = '0;
    if (mt >= 0) begin e.way = WW'(mt); e.perm = m_perm[s][mt]; end
    case (op)
      4'd1: begin
        e.hit = (mt >= 0) && (m_perm[s][mt] == 2'd3 ||
                (m_perm[s][mt] == 2'd2 && kind != 2'd2));
        if (mt >= 0) m_touch(s, mt);
      end
      4'd2: begin e.hit = (mt >= 0); if (mt >= 0) m_touch(s, mt); end
      4'd3: e.hit = (mt >= 0);
      4'd4: e.hit = avail;
      4'd5: begin
        if (mt >= 0 || fr < 0) e.err = 1;
        else begin
          e.hit = 1; e.way = WW'(fr); e.perm = 2'd1;
          m_tag[s][fr] = addr; m_perm[s][fr] = 2'd1; m_touch(s, fr);
        end
      end
      4'd6: begin e.err = (mt < 0); e.hit = (mt >= 0); if (mt >= 0) m_perm[s][mt] = 2'd0; end
      4'd7: begin e.err = (mt < 0); e.hit = (mt >= 0); if (mt >= 0) m_perm[s][mt] = perm; end
      4'd8: begin
        if (avail) e.err = 1;
        else begin e.way = WW'(vw); e.perm = m_perm[s][vw]; e.victim = m_tag[s][vw]; end
      end
      default: begin e.err = (mt < 0); e.hit = (mt >= 0); if (mt >= 0) m_touch(s, mt); end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(rtag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: one prediction consumed per response, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t  a, e;
      string t;
      a = {rsp_hit, rsp_way, rsp_perm, rsp_victim, rsp_error};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: response with no pending command, actual=%h expected=none", a);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual hit=%b way=%0d perm=%0d victim=%h err=%b expected hit=%b way=%0d perm=%0d victim=%h err=%b",
                   t, a.hit, a.way, a.perm, a.victim, a.err,
                   e.hit, e.way, e.perm, e.victim, e.err);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_kind = '0; req_addr = '0; req_perm = '0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_tag[s][w] = '0; m_perm[s][w] = 2'd0; m_age[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rsp_valid actual=%b expected=0", rsp_valid);
    end
    // R1: empty directory
    issue("R1", 4'd3, 16'h0000, 2'd0, 2'd0);
    issue("R1", 4'd3, 16'h0021, 2'd0, 2'd0);
    issue("R7", 4'd4, 16'h0050, 2'd0, 2'd0);
    // R8: fill set 0 in way order
    issue("R8", 4'd5, 16'h0010, 2'd0, 2'd0);
    issue("R8", 4'd5, 16'h0020, 2'd0, 2'd0);
    issue("R8", 4'd5, 16'h0030, 2'd0, 2'd0);
    issue("R8", 4'd5, 16'h0040, 2'd0, 2'd0);
    // R9: full set and duplicate
    issue("R9", 4'd5, 16'h0050, 2'd0, 2'd0);
    issue("R9", 4'd5, 16'h0020, 2'd0, 2'd0);
    issue("R9", 4'd3, 16'h0050, 2'd0, 2'd0);
    // R3: set index from low bits, other set untouched
    issue("R3", 4'd3, 16'h0011, 2'd0, 2'd0);
    issue("R8", 4'd5, 16'h0011, 2'd0, 2'd0);
    // R4/R5 on an Invalid line
    issue("R4", 4'd1, 16'h0010, 2'd0, 2'd0);
    issue("R5", 4'd2, 16'h0010, 2'd2, 2'd0);
    // R10 permission changes, then R4 on ReadOnly / ReadWrite
    issue("R10", 4'd7, 16'h0010, 2'd0, 2'd2);
    issue("R4", 4'd1, 16'h0010, 2'd0, 2'd0);
    issue("R4", 4'd1, 16'h0010, 2'd1, 2'd0);
    issue("R4", 4'd1, 16'h0010, 2'd2, 2'd0);
    issue("R10", 4'd7, 16'h0020, 2'd0, 2'd3);
    issue("R4", 4'd1, 16'h0020, 2'd2, 2'd0);
    // R7: full set availability
    issue("R7", 4'd4, 16'h0050, 2'd0, 2'd0);
    issue("R7", 4'd4, 16'h0030, 2'd0, 2'd0);
    // R11/R6: probe, reorder with refused access and touches, probe again
    issue("R11", 4'd8, 16'h0050, 2'd0, 2'd0);
    issue("R6", 4'd1, 16'h0030, 2'd2, 2'd0);
    issue("R11", 4'd8, 16'h0050, 2'd0, 2'd0);
    issue("R12", 4'd9, 16'h0040, 2'd0, 2'd0);
    issue("R12", 4'd9, 16'h0010, 2'd0, 2'd0);
    issue("R11", 4'd8, 16'h0050, 2'd0, 2'd0);
    // R12: bad touch and probe of an available set
    issue("R12", 4'd9, 16'h0060, 2'd0, 2'd0);
    issue("R12", 4'd8, 16'h0001, 2'd0, 2'd0);
    // R10: free, refused free, refill lowest hole
    issue("R10", 4'd6, 16'h0030, 2'd0, 2'd0);
    issue("R10", 4'd6, 16'h0030, 2'd0, 2'd0);
    issue("R10", 4'd7, 16'h0030, 2'd0, 2'd3);
    issue("R7", 4'd4, 16'h0050, 2'd0, 2'd0);
    issue("R8", 4'd5, 16'h0050, 2'd0, 2'd0);
    issue("R11", 4'd8, 16'h0060, 2'd0, 2'd0);
    idle(2);
    // mixed run over a small address pool in two sets
    for (int i = 0; i < 600; i++) begin
      logic [3:0]    op;
      logic [AW-1:0] ad;
      op = 4'(1 + ($urandom % 9));
      ad = AW'(((1 + ($urandom % 6)) << SB) | ($urandom % 2));
      issue(req_of(op), op, ad, 2'($urandom % 3), 2'($urandom % 4));
      if (($urandom % 8) == 0) idle(1);
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending predictions actual=%0d expected=0", exp_q.size());
    end
    summary();
  end

endmodule